// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block compares the running calendar-clock fields (seconds, minutes, hours and day of month) against a bank of programmable alarm registers. Each alarm register holds a two-digit BCD value and a mask bit. A field whose mask bit is set drops out of the comparison. Because each field has its own mask, software can program alarms that repeat once a second, once a minute, once an hour or once a day. It can also program a single date-and-time alarm.

The timekeeping logic outside the block gives it the current BCD fields and a one-cycle `tick_i` pulse each time the time advances by one second. The comparison is taken only on that pulse, so a match can produce at most one alarm event per second. An event sets a sticky alarm flag, which stays set until a read strobe clears it. The interrupt output is the flag gated by an enable input. Any write to an alarm register cancels an event that is still in flight, so a match against stale settings never reaches the flag.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset `alm_flag_o` and `irq_o` are 0, and every alarm register reads 0x80, which means all fields are masked.
- R2: A cycle with `alm_wr_i`=1 loads `alm_wdata_i` into the alarm register chosen by `alm_sel_i`: 0 is seconds, 1 is minutes, 2 is hours, 3 is day of month. Bit 7 is the mask bit. Bits 6:0 hold the BCD value (tens in 6:4, units in 3:0) and are compared with bits 6:0 of the matching time field. Within `now_time_i`, seconds are bits 7:0, minutes 15:8, hours 23:16 and day 31:24.
- R3: The comparison is taken only in cycles with `tick_i`=1. When every enabled field matches at the edge that samples the tick, `alm_flag_o` reads 1 after the following edge, two edges later. A match that persists across cycles without a tick raises no further event.
- R4: A field whose mask bit is 1 never blocks a match. With all four mask bits set, every tick produces an event.
- R5: A field whose mask bit is 0 and whose value differs from the current time blocks the event.
- R6: `alm_flag_o` stays 1 until a cycle with `flag_rd_i`=1, and then reads 0 after that edge. If a new event lands in the same cycle as the read, the flag stays 1.
- R7: A write to any alarm register cancels an event. This applies when the write comes in the same cycle as the tick or in the cycle after it, and the flag is then not set by that event.
- R8: `irq_o` equals `alm_flag_o` AND `irq_en_i`, with no added latency from `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse when the time fields advance by one second |
| now_time_i | input | NUM_FIELDS*FIELD_W | Current BCD time fields, seconds in the lowest byte |
| alm_wr_i | input | 1 | Alarm register write strobe |
| alm_sel_i | input | SEL_W | Alarm register index |
| alm_wdata_i | input | FIELD_W | Alarm register write data (mask bit on top) |
| irq_en_i | input | 1 | Alarm interrupt enable |
| flag_rd_i | input | 1 | Flag read strobe; clears the alarm flag |
| alm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with its default parameters, which give four fields of eight bits. The seconds, minutes, hours and day registers and their shared mask position are therefore all reached in full. Random time values are drawn from a pool of three BCD codes, and alarm values from the same pool, so partial and full matches happen often. Writes, reads and ticks are mixed randomly, which causes collisions between writes and in-flight events and between reads and new events. Directed sequences cover the reset state (all fields masked), a single blocking field, flag retention and the two cancel windows.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // Flag pipeline state: a match waiting one cycle, and the sticky flag.
    typedef struct packed {
        logic pend;
        logic flag;
    } alarm_flag_state_t;

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int FIELD_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [FIELD_W-1:0] wdata_i,
    input  logic [FIELD_W-1:0] now_i,
    output logic               hit_o
);
    localparam int VAL_W = FIELD_W - 1;

    typedef struct packed {
        logic [FIELD_W-1:0] setting;
    } field_state_t;

    field_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.setting = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.setting <= {1'b1, {VAL_W{1'b0}}};
        end else begin
            st_q <= st_d;
        end
    end

    // Top bit masks the field out; otherwise the BCD digits must agree.
    assign hit_o = st_q.setting[FIELD_W-1]
                 | (st_q.setting[VAL_W-1:0] == now_i[VAL_W-1:0]);

endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
    import alarm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic all_hit_i,
    input  logic any_wr_i,
    input  logic rd_clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    alarm_flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Sample the comparison once per second; a write kills it.
        st_d.pend = tick_i & all_hit_i & ~any_wr_i;
        // A new event wins over a same-cycle read.
        st_d.flag = (st_q.pend & ~any_wr_i) | (st_q.flag & ~rd_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
    parameter  int NUM_FIELDS = 4,
    parameter  int FIELD_W    = 8,
    localparam int SEL_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tick_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] now_time_i,
    input  logic                          alm_wr_i,
    input  logic [SEL_W-1:0]              alm_sel_i,
    input  logic [FIELD_W-1:0]            alm_wdata_i,
    input  logic                          irq_en_i,
    input  logic                          flag_rd_i,
    output logic                          alm_flag_o,
    output logic                          irq_o
);
    logic [NUM_FIELDS-1:0] wr_vec;
    logic [NUM_FIELDS-1:0] hit_vec;

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        assign wr_vec[gi] = alm_wr_i && (alm_sel_i == SEL_W'(gi));

        alarm_field_cmp #(
            .FIELD_W (FIELD_W)
        ) u_cmp (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_vec[gi]),
            .wdata_i (alm_wdata_i),
            .now_i   (now_time_i[gi*FIELD_W +: FIELD_W]),
            .hit_o   (hit_vec[gi])
        );
    end

    alarm_flag_ctrl u_flag (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .all_hit_i (&hit_vec),
        .any_wr_i  (alm_wr_i),
        .rd_clr_i  (flag_rd_i),
        .irq_en_i  (irq_en_i),
        .flag_o    (alm_flag_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tick_i,
    input logic alm_wr_i,
    input logic irq_en_i,
    input logic flag_rd_i,
    input logic alm_flag_o,
    input logic irq_o
);
    // R8: interrupt only with flag and enable present
    a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (alm_flag_o && irq_en_i));

    // R6: flag is sticky until read
    a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alm_flag_o && !flag_rd_i) |=> alm_flag_o);

    // R6: read clears when no event is arriving (events need a tick one cycle earlier)
    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_rd_i && !$past(tick_i)) |=> !alm_flag_o);

    // R3: a rising flag traces back to a tick two edges earlier
    a_r3_rise_from_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alm_flag_o) |-> $past(tick_i, 2));

    // R7: a write keeps a clear flag clear on the next edge
    a_r7_write_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alm_wr_i && !alm_flag_o) |=> !alm_flag_o);

endmodule

bind alarm_match_unit alarm_match_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .alm_wr_i   (alm_wr_i),
    .irq_en_i   (irq_en_i),
    .flag_rd_i  (flag_rd_i),
    .alm_flag_o (alm_flag_o),
    .irq_o      (irq_o)
);

// File: tb/alarm_match_unit_bench.sv
`timescale 1ns/1ps
module alarm_match_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] now_time = '0;
    logic        wr = 1'b0;
    logic [1:0]  sel = '0;
    logic [7:0]  wdata = '0;
    logic        irq_en = 1'b0;
    logic        rd = 1'b0;
    logic        flag, irq;

    int checks = 0;
    int errors = 0;

    // Reference state, derived from the requirements
    logic [7:0] m_reg [4];
    logic       m_pend, m_flag;

    always #2.5 clk = ~clk;

    alarm_match_unit u_alarm_match_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .now_time_i  (now_time),
        .alm_wr_i    (wr),
        .alm_sel_i   (sel),
        .alm_wdata_i (wdata),
        .irq_en_i    (irq_en),
        .flag_rd_i   (rd),
        .alm_flag_o  (flag),
        .irq_o       (irq)
    );

    function automatic logic ref_hit(input logic [31:0] tm);
        logic h = 1'b1;
        for (int f = 0; f < 4; f++) begin
            if (!m_reg[f][7] && (m_reg[f][6:0] != tm[f*8 +: 7])) h = 1'b0;
        end
        return h;
    endfunction

    function automatic logic [7:0] pick_bcd();
        case ($urandom % 3)
            0:       return 8'h00;
            1:       return 8'h15;
            default: return 8'h59;
        endcase
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic step(input logic tk, input logic [31:0] tm, input logic w,
                        input logic [1:0] s, input logic [7:0] wd,
                        input logic r, input logic en);
        logic np, nf;
        @(negedge clk);
        tick = tk; now_time = tm; wr = w; sel = s; wdata = wd; rd = r; irq_en = en;
        @(posedge clk);
        np = tk & ref_hit(tm) & ~w;
        nf = (m_pend & ~w) | (m_flag & ~r);
        if (w) m_reg[s] = wd;
        m_pend = np;
        m_flag = nf;
        #1;
    endtask

    task automatic idle(input logic en);
        step(1'b0, now_time, 1'b0, 2'd0, 8'h00, 1'b0, en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        for (int f = 0; f < 4; f++) m_reg[f] = 8'h80;
        m_pend = 1'b0; m_flag = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flag after reset", flag, 1'b0);
        chk("R1 irq after reset", irq, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R1/R4: reset leaves all fields masked, so any tick fires
        step(1'b1, 32'h0312_4507, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        chk("R3 not yet after one edge", flag, 1'b0);
        idle(1'b0);
        chk("R4 all masked fires", flag, 1'b1);
        chk("R8 irq gated off", irq, 1'b0);
        idle(1'b1);
        chk("R8 irq with enable", irq, 1'b1);
        step(1'b0, now_time, 1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
        chk("R6 read clears", flag, 1'b0);

        // R2/R5: seconds 30, minutes 45, hours/day masked
        step(1'b0, now_time, 1'b1, 2'd0, 8'h30, 1'b0, 1'b0);
        step(1'b0, now_time, 1'b1, 2'd1, 8'h45, 1'b0, 1'b0);
        step(1'b1, 32'h0102_4430, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        idle(1'b0);
        chk("R5 minutes mismatch blocks", flag, 1'b0);
        step(1'b1, 32'h0923_4530, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        idle(1'b0);
        chk("R2 R4 match with masked hour and day", flag, 1'b1);
        repeat (5) idle(1'b0);
        chk("R6 flag held without read", flag, 1'b1);
        step(1'b0, now_time, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
        chk("R6 read clears again", flag, 1'b0);

        // R3: match persists without further ticks -> no retrigger
        repeat (4) idle(1'b0);
        chk("R3 no retrigger without tick", flag, 1'b0);

        // R7: write in the tick cycle, then write one cycle after
        step(1'b1, 32'h0923_4530, 1'b1, 2'd0, 8'h30, 1'b0, 1'b0);
        idle(1'b0); idle(1'b0);
        chk("R7 write with tick cancels", flag, 1'b0);
        step(1'b1, 32'h0923_4530, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        step(1'b0, now_time, 1'b1, 2'd3, 8'h80, 1'b0, 1'b0);
        idle(1'b0);
        chk("R7 write after tick cancels", flag, 1'b0);

        // R6: read collides with a new event
        step(1'b1, 32'h0923_4530, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        idle(1'b0);
        chk("R3 event sets flag", flag, 1'b1);
        step(1'b1, 32'h0923_4530, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
        step(1'b0, now_time, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
        chk("R6 new event beats read", flag, 1'b1);

        // Random mix against the reference state
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] tm;
            logic [7:0]  wd;
            tm = {pick_bcd(), pick_bcd(), pick_bcd(), pick_bcd()};
            wd = {1'(($urandom % 3) == 0), pick_bcd()};
            step(1'(($urandom % 2) == 0), tm, 1'(($urandom % 8) == 0),
                 2'($urandom % 4), wd, 1'(($urandom % 4) == 0),
                 1'(($urandom % 2) == 0));
            chk("R3 R4 R5 R6 R7 random flag", flag, m_flag);
            chk("R8 random irq", irq, m_flag & irq_en);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule